// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Arbiter

This block takes interrupt requests from sixteen peripheral sources and two sources that no mask can block: a non-maskable interrupt (NMI) input and an address-break input. It works out which request, if any, goes to the CPU. Every peripheral source has its own enable bit and a one-bit priority level. Both are held in control registers that load from a simple write strobe. A single global mask bit, which copies the CPU's condition-code interrupt mask, holds back all peripheral requests. It never holds back NMI or address break.

The choice is made in two stages. First, a request at level 1 wins over any request at level 0. Second, among requests at the same level, the one with the lowest source index wins. NMI comes before address break, and both come before every peripheral source. The winner is handed over only when the CPU signals an instruction boundary. At that point the block gives a one-cycle accept pulse with a 6-bit vector number and sets the mask bit. A separate mask-clear input stands in for a return from exception and clears the mask again.

Top module: `irq_arbiter`

## Requirements
- R1: A peripheral source n can be chosen only while its flag input `src_flag[n]` is 1 and its enable bit is 1. A cycle with `cfg_wr`=1 loads the enable bits from `cfg_en` and the level bits from `cfg_lvl` at the clock edge.
- R2: A pending peripheral request with level bit 1 wins over every pending peripheral request with level bit 0. The level-0 requests stay pending.
- R3: Among pending peripheral requests at the same level, the lowest index wins. The others stay pending and can be taken at later boundaries.
- R4: While `mask_bit` is 1, no peripheral request is accepted.
- R5: NMI and address-break requests are accepted whatever the value of `mask_bit` and whatever the level bits hold.
- R6: A request is accepted only at a clock edge where `insn_done` is 1. `take_pulse` is 1 for exactly the cycle after that edge, and there is no pulse when nothing is pending.
- R7: At every acceptance, `mask_bit` becomes 1.
- R8: NMI is latched on a rising edge of `nmi_in` and stays pending until it is accepted. Holding the input high does not raise a second request. Address break is level-sensitive. The fixed order is NMI, then address break, then the peripheral sources.
- R9: `take_vec` holds 7 for NMI, 8 for address break and 16+n for peripheral source n. It is valid in the cycle when `take_pulse` is 1.
- R10: `mask_clr`=1 clears `mask_bit` at the next clock edge. If an acceptance happens at the same edge, `mask_bit` is 1 instead.
- R11: After reset, `mask_bit` is 1, all enables and levels are 0, no NMI is latched and `take_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_flag | input | 16 | Level-sensitive peripheral interrupt flags |
| cfg_wr | input | 1 | Load strobe for the enable and level registers |
| cfg_en | input | 16 | Enable bits to load |
| cfg_lvl | input | 16 | Priority level bits to load |
| nmi_in | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| abrk_in | input | 1 | Address-break request, level-sensitive |
| insn_done | input | 1 | Instruction-boundary strobe from the CPU |
| mask_clr | input | 1 | Clears the global mask bit |
| take_pulse | output | 1 | One-cycle acceptance pulse |
| take_vec | output | 6 | Vector number of the accepted request |
| mask_bit | output | 1 | Global interrupt mask |

## Verification
The selection is tried with several patterns. A single enabled source checks the vector mapping. A flagged but disabled source shows that the enable gate works. Two sources at equal level show the index order and that the loser is kept. Two sources at different levels, where the higher index carries level 1, tell the level stage apart from the index stage. NMI and address break are raised while the mask is set, and also against a pending level-1 source, to show that they bypass the mask and take their fixed order. An NMI held high checks edge latching. Cycles without a boundary strobe, and a mask clear that arrives in the same cycle as an acceptance, check the timing rules.

// File: rtl/irq_arb_pkg.sv
// Shared constants and types for the interrupt arbiter.
// Assumes vectors fit in VEC_W bits for the configured source count.
package irq_arb_pkg;
    localparam int VEC_W         = 6;
    localparam int VEC_NMI       = 7;
    localparam int VEC_ABRK      = 8;
    localparam int VEC_SRC_BASE  = 16;

    // Which class of request won this cycle's selection.
    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_NMI  = 2'd1,
        WIN_ABRK = 2'd2,
        WIN_SRC  = 2'd3
    } win_kind_e;
endpackage

// File: rtl/irq_cfg_regs.sv
// Per-source enable and priority-level registers.
// Loads both vectors on a write strobe; both clear on reset.
module irq_cfg_regs #(
    parameter int N_SRC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [N_SRC-1:0] en_d,
    input  logic [N_SRC-1:0] lvl_d,
    output logic [N_SRC-1:0] en_q,
    output logic [N_SRC-1:0] lvl_q
);
    // Hold the configuration, replacing it on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            lvl_q <= '0;
        end else if (wr) begin
            en_q  <= en_d;
            lvl_q <= lvl_d;
        end
    end
endmodule

// File: rtl/irq_edge_latch.sv
// Rising-edge detector with a sticky pending flag.
// A new edge at the same clock as a clear keeps the flag set.
module irq_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    input  logic clear,
    output logic pend
);
    logic lvl_q;
    logic rise;

    // Flag a low-to-high transition of the input.
    always_comb rise = lvl_in && !lvl_q;

    // Track the previous input and hold the pending flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            lvl_q <= lvl_in;
            pend  <= (pend && !clear) || rise;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-order priority encoder: the lowest set index wins.
// Purely combinational; idx is zero when nothing is set.
module irq_prio_pick #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the lowest set index is the last written.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// Two-level maskable interrupt arbiter.
// Picks NMI, then address break, then the best peripheral request
// (level 1 before level 0, lowest index within a level), and hands
// it over at an instruction boundary while setting the global mask.
// Assumes the flag inputs are synchronous to clk.
module irq_arbiter #(
    parameter int N_SRC = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N_SRC-1:0]                 src_flag,
    input  logic                             cfg_wr,
    input  logic [N_SRC-1:0]                 cfg_en,
    input  logic [N_SRC-1:0]                 cfg_lvl,
    input  logic                             nmi_in,
    input  logic                             abrk_in,
    input  logic                             insn_done,
    input  logic                             mask_clr,
    output logic                             take_pulse,
    output logic [irq_arb_pkg::VEC_W-1:0]    take_vec,
    output logic                             mask_bit
);
    import irq_arb_pkg::*;

    localparam int IDX_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam int N_LVL  = 2;

    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] lvl_q;
    logic             nmi_pend;
    logic             accept;
    logic             take_nmi;
    win_kind_e        win_kind;
    logic [VEC_W-1:0] win_vec;

    logic [N_SRC-1:0] lvl_req   [N_LVL];
    logic             lvl_found [N_LVL];
    logic [IDX_W-1:0] lvl_idx   [N_LVL];
    logic [N_SRC-1:0] live_req;

    irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .en_d  (cfg_en),
        .lvl_d (cfg_lvl),
        .en_q  (en_q),
        .lvl_q (lvl_q)
    );

    irq_edge_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (nmi_in),
        .clear  (take_nmi),
        .pend   (nmi_pend)
    );

    // Enabled peripheral requests that the mask lets through.
    always_comb live_req = src_flag & en_q & {N_SRC{!mask_bit}};

    // One priority encoder per control level.
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        always_comb lvl_req[g] = live_req & ((g == 1) ? lvl_q : ~lvl_q);

        irq_prio_pick #(.N(N_SRC), .IDX_W(IDX_W)) u_pick (
            .req   (lvl_req[g]),
            .found (lvl_found[g]),
            .idx   (lvl_idx[g])
        );
    end

    // Fixed order between classes, then the level stage, then the index.
    always_comb begin
        win_kind = WIN_NONE;
        win_vec  = '0;
        if (nmi_pend) begin
            win_kind = WIN_NMI;
            win_vec  = VEC_W'(VEC_NMI);
        end else if (abrk_in) begin
            win_kind = WIN_ABRK;
            win_vec  = VEC_W'(VEC_ABRK);
        end else if (lvl_found[1]) begin
            win_kind = WIN_SRC;
            win_vec  = VEC_W'(VEC_SRC_BASE) + VEC_W'(lvl_idx[1]);
        end else if (lvl_found[0]) begin
            win_kind = WIN_SRC;
            win_vec  = VEC_W'(VEC_SRC_BASE) + VEC_W'(lvl_idx[0]);
        end
    end

    // Acceptance happens only at an instruction boundary with a winner.
    always_comb begin
        accept   = insn_done && (win_kind != WIN_NONE);
        take_nmi = accept && (win_kind == WIN_NMI);
    end

    // Register the hand-over and hold the vector between pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_pulse <= 1'b0;
            take_vec   <= '0;
        end else begin
            take_pulse <= accept;
            if (accept) take_vec <= win_vec;
        end
    end

    // Global mask: set on acceptance, which wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        mask_bit <= 1'b1;
        else if (accept)   mask_bit <= 1'b1;
        else if (mask_clr) mask_bit <= 1'b0;
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
// Assertion checker for the interrupt arbiter, attached by bind.
// Observes ports plus the latched NMI flag; drives nothing.
module irq_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       insn_done,
    input logic       mask_clr,
    input logic       take_pulse,
    input logic [5:0] take_vec,
    input logic       mask_bit,
    input logic       nmi_pend
);
    AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> $past(insn_done)); // R6
    AST_MASK_SET_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> mask_bit); // R7
    AST_MASKED_ONLY_NONMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pulse && $past(mask_bit) && $past(rst_n)) |-> (take_vec == 6'd7 || take_vec == 6'd8)); // R4
    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_pulse && $past(nmi_pend) && $past(rst_n)) |-> (take_vec == 6'd7)); // R8
    AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        take_pulse |-> (take_vec == 6'd7 || take_vec == 6'd8 || (take_vec >= 6'd16 && take_vec <= 6'd31))); // R9
    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask_clr) && $past(rst_n) && !take_pulse) |-> !mask_bit); // R10
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .insn_done  (insn_done),
    .mask_clr   (mask_clr),
    .take_pulse (take_pulse),
    .take_vec   (take_vec),
    .mask_bit   (mask_bit),
    .nmi_pend   (nmi_pend)
);

// File: tb/irq_arbiter_bench.sv
// Scoreboard bench: the driver queues expected vectors, the monitor
// pops and compares them on every accept pulse.
module irq_arbiter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_flag = '0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_en = '0;
    logic [15:0] cfg_lvl = '0;
    logic        nmi_in = 1'b0;
    logic        abrk_in = 1'b0;
    logic        insn_done = 1'b0;
    logic        mask_clr = 1'b0;
    logic        take_pulse;
    logic [5:0]  take_vec;
    logic        mask_bit;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_arbiter u_irq_arbiter (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .cfg_wr(cfg_wr),
        .cfg_en(cfg_en), .cfg_lvl(cfg_lvl), .nmi_in(nmi_in), .abrk_in(abrk_in),
        .insn_done(insn_done), .mask_clr(mask_clr), .take_pulse(take_pulse),
        .take_vec(take_vec), .mask_bit(mask_bit)
    );

    // Monitor: compare each accept pulse against the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && take_pulse) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected accept, vector %0d, expected none", "R6", take_vec);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (take_vec != 6'(e)) begin
                    errors++;
                    $display("FAIL %s: vector %0d, expected %0d", t, take_vec, e);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
        end
    endtask

    // Driver: one instruction boundary; exp < 0 means no acceptance.
    task automatic boundary(input int exp, input string tag);
        @(negedge clk);
        if (exp >= 0) begin
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        insn_done = 1'b1;
        @(negedge clk);
        insn_done = 1'b0;
        #1;
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
    endtask

    task automatic clear_mask();
        @(negedge clk);
        mask_clr = 1'b1;
        @(negedge clk);
        mask_clr = 1'b0;
    endtask

    task automatic configure(input logic [15:0] en, input logic [15:0] lvl);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_en = en; cfg_lvl = lvl;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(mask_bit == 1'b1, "R11", mask_bit, 1);
        check(take_pulse == 1'b0, "R11", take_pulse, 0);
        src_flag[4] = 1'b1;
        clear_mask();
        boundary(-1, "R11"); // enables reset to 0: nothing taken

        // R4: masked peripheral request held
        configure(16'h0008, 16'h0000);
        src_flag = 16'h0008;
        @(negedge clk); mask_clr = 1'b0;
        insn_done = 1'b0;
        // set mask again via a quick NMI so mask is 1
        nmi_in = 1'b1;
        boundary(7, "R5");
        nmi_in = 1'b0;
        check(mask_bit == 1'b1, "R7", mask_bit, 1);
        boundary(-1, "R4");

        // R10 / R9: clear mask, source 3 taken as vector 19
        clear_mask();
        check(mask_bit == 1'b0, "R10", mask_bit, 0);
        boundary(19, "R9");
        check(mask_bit == 1'b1, "R7", mask_bit, 1);
        src_flag = '0;

        // R1: flag without enable is ignored
        src_flag[5] = 1'b1;
        clear_mask();
        boundary(-1, "R1");
        src_flag = '0;

        // R3: equal levels, lowest index first, loser kept
        configure(16'h0204, 16'h0000);
        src_flag = 16'h0204;
        boundary(18, "R3");
        src_flag[2] = 1'b0;
        clear_mask();
        boundary(25, "R3");
        src_flag = '0;

        // R2: level 1 beats lower index at level 0
        configure(16'h1002, 16'h1000);
        src_flag = 16'h1002;
        clear_mask();
        boundary(28, "R2");
        src_flag[12] = 1'b0;
        clear_mask();
        // R6: no boundary strobe, no acceptance
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(take_pulse == 1'b0, "R6", take_pulse, 0);
        end
        boundary(17, "R2");
        src_flag = '0;

        // R5 / R8: NMI and address break while masked, fixed order
        check(mask_bit == 1'b1, "R4", mask_bit, 1);
        @(negedge clk);
        nmi_in = 1'b1; abrk_in = 1'b1;
        boundary(7, "R8");
        boundary(8, "R8");
        abrk_in = 1'b0;
        boundary(-1, "R8"); // NMI still high: no second request
        nmi_in = 1'b0;

        // R8: NMI beats a pending level-1 peripheral request
        src_flag = 16'h1000;
        clear_mask();
        @(negedge clk);
        nmi_in = 1'b1;
        boundary(7, "R8");
        nmi_in = 1'b0;
        src_flag = '0;

        // R10: mask clear coinciding with acceptance -> mask stays 1
        clear_mask();
        @(negedge clk);
        abrk_in = 1'b1;
        exp_q.push_back(8); tag_q.push_back("R10");
        insn_done = 1'b1; mask_clr = 1'b1;
        @(negedge clk);
        insn_done = 1'b0; mask_clr = 1'b0; abrk_in = 1'b0;
        #1;
        check(exp_q.size() == 0, "R10", exp_q.size(), 0);
        check(mask_bit == 1'b1, "R10", mask_bit, 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, got hang, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule